// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a raw asynchronous NAND flash bus from a small register file. Software loads a control word carrying two address cycle counts, fills one of two address sets (a low word holding column and low page bits, a high word holding the upper page bits), sets a transfer length, and then writes a command word. That single write starts a predefined multi-phase bus sequence: command latch cycles, address latch cycles, waits on the ready lines, and data cycles. The sequence is picked by a 6-bit code, and it draws up to two opcode bytes from the command word.

Read data leaves the block on a byte stream (`rd_valid`/`rd_byte`). Write data is taken from `wr_byte` each time `wr_take` pulses. A status-read sequence instead places its byte in a read-status register. An interrupt line reports command completion and per-chip ready edges through a mask.

Bus-engine states: `ST_IDLE` (waits for an accepted command write), `ST_SETUP` (one cycle in which CLE/ALE/IO settle with both strobes high), `ST_WE_LO` and `ST_WE_HI` (write strobe low then high, each `PULSE_CYC` cycles), `ST_RE_LO` and `ST_RE_HI` (read strobe low, with the sample taken on its last cycle, then high), `ST_WAIT_RB` (a short guard, then a wait until all ready lines are high) and `ST_FINISH` (raises command-end, returns to `ST_IDLE`). Transitions: IDLE→SETUP on start; SETUP→WE_LO for command, address and write-data phases, SETUP→RE_LO for read phases; WE_LO→WE_HI and RE_LO→RE_HI after the low time; WE_HI/RE_HI→SETUP when more bytes remain in the phase, otherwise to the entry state of the next enabled phase (SETUP, WAIT_RB or FINISH); WAIT_RB→next phase once ready; FINISH→IDLE. Phases run in this fixed order, each skipped if the code does not use it: first opcode, address, mid confirm + wait, write data, end confirm + wait, read data, status byte, end.

Top module: `nand_seq_engine`

## Requirements
- R1: After reset CLE and ALE are low, WE# and RE# are high, IO is not driven, `irq` is low, and status bits 8 (busy) and 9 (collision) read 0.
- R2: Command word fields: bits 5:0 are the sequence code, bit 7 selects address set 1, bits 15:8 are the first opcode and bits 23:16 the second. Code 0x00 issues exactly one CLE cycle carrying the first opcode and then raises command-end (interrupt status bit 1).
- R3: Address bytes come from the 64-bit value {high word, low word} of the chosen set, least significant byte first. Code 0x21 sends 1 byte, code 0x27 sends 3 and code 0x2a sends 5. Codes 0x21 and 0x27 then read the data length in bytes.
- R4: Code 0x2a sends first opcode, 5 address bytes, second opcode, waits for ready, then reads the data length in bytes onto the stream in bus order.
- R5: Code 0x0e (erase) sends the first opcode, then page bytes only (starting at byte 2 of the address value) for the set's control count, then the second opcode, and raises command-end only after all ready lines are high again.
- R6: Code 0x0c (program) sends the first opcode, the set's control count of address bytes from byte 0, the data length of bytes taken from `wr_byte` in order, then the second opcode, and waits for ready before command-end.
- R7: Code 0x24 sends one opcode and reads one byte; that byte appears in bits 7:0 of the read-status register (index 10) and not on the stream.
- R8: Control bits 2:0 give the address count of set 0 and bits 20:18 that of set 1; command bit 7 picks set 1 and its count.
- R9: Status register (index 2) bits 7:0 mirror the eight ready lines, bit 8 is busy. A command write while busy is ignored and sets sticky bit 9; any write to the status register clears bit 9.
- R10: Interrupt status bit 1 marks command-end and bit 4+n marks a rising edge of ready line n. `irq` is the OR of status bits ANDed with the mask register (index 3). Writing zero to interrupt status (index 4) clears all bits; a nonzero write changes nothing.
- R11: WE# and RE# low times are exactly `PULSE_CYC` cycles, high times at least `PULSE_CYC`. CLE and ALE do not change in the cycle where WE# falls. The two strobes are never low together, and IO is driven whenever WE# is low and never while RE# is low.
- R12: A command write with a code outside the seven listed above starts nothing: no bus cycle, no busy, no command-end.
- R13: A data length of zero skips the data phase of a read or program sequence; the rest of the sequence still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | IO byte driven to flash |
| nand_io_oe | output | 1 | IO output enable |
| nand_io_in | input | 8 | IO byte from flash |
| dev_rdy | input | 8 | Ready/busy lines of eight chip selects |
| rd_valid | output | 1 | Read stream byte valid |
| rd_byte | output | 8 | Read stream byte |
| wr_byte | input | 8 | Next byte to program |
| wr_take | output | 1 | Pulse: `wr_byte` is consumed |
| irq | output | 1 | Masked interrupt |

Register indexes: 0 control, 1 command, 2 status, 3 mask, 4 interrupt status, 5/6 set 0 low/high, 7/8 set 1 low/high, 9 data length, 10 read-status.

## Verification
All seven sequence codes are run from one vector table with the same address and length setup. Comparing the counts of command, address, write and read bus cycles separates each code's phase list from the others. Directed runs then vary the address set (set 0 with count 4 against set 1 with count 3), the data length (4 against 0), and illegal or overlapping command writes. These runs distinguish the byte ordering, the choice between page-only and full address, count selection, skipping of the data phase, and collision handling. A flash model that holds ready low after each confirm opcode shows whether command-end waits for ready and whether the ready-edge interrupt fires.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int CHIP_N = 8;
    localparam int IRQ_W  = 4 + CHIP_N;

    localparam logic [5:0] SEQ_CMD_ONLY  = 6'h00;
    localparam logic [5:0] SEQ_A1_READ   = 6'h21;
    localparam logic [5:0] SEQ_A3_READ   = 6'h27;
    localparam logic [5:0] SEQ_A5_C_READ = 6'h2A;
    localparam logic [5:0] SEQ_ERASE     = 6'h0E;
    localparam logic [5:0] SEQ_PROGRAM   = 6'h0C;
    localparam logic [5:0] SEQ_STATUS    = 6'h24;

    localparam logic [3:0] RG_CTRL    = 4'd0;
    localparam logic [3:0] RG_CMD     = 4'd1;
    localparam logic [3:0] RG_STATUS  = 4'd2;
    localparam logic [3:0] RG_MASK    = 4'd3;
    localparam logic [3:0] RG_ISTAT   = 4'd4;
    localparam logic [3:0] RG_S0_LO   = 4'd5;
    localparam logic [3:0] RG_S0_HI   = 4'd6;
    localparam logic [3:0] RG_S1_LO   = 4'd7;
    localparam logic [3:0] RG_S1_HI   = 4'd8;
    localparam logic [3:0] RG_LEN     = 4'd9;
    localparam logic [3:0] RG_RDSTAT  = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_WE_LO, ST_WE_HI,
        ST_RE_LO, ST_RE_HI, ST_WAIT_RB, ST_FINISH
    } bus_state_t;

    typedef enum logic [3:0] {
        PH_CMD0, PH_ADDR, PH_CONF_MID, PH_WAIT_MID, PH_WDATA,
        PH_CONF_END, PH_WAIT_END, PH_RDATA, PH_STAT, PH_END
    } phase_t;

    typedef struct packed {
        logic       known;
        logic [2:0] fixed_addr;
        logic       use_ctrl_cnt;
        logic       row_only;
        logic       mid_conf;
        logic       wdata;
        logic       end_conf;
        logic       rdata;
        logic       stat;
    } seq_desc_t;
endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
    import nand_seq_pkg::*;
(
    input  logic [5:0] code,
    output seq_desc_t  desc
);
    always_comb begin
        desc = '0;
        case (code)
            SEQ_CMD_ONLY:  desc.known = 1'b1;
            SEQ_A1_READ: begin
                desc.known = 1'b1; desc.fixed_addr = 3'd1; desc.rdata = 1'b1;
            end
            SEQ_A3_READ: begin
                desc.known = 1'b1; desc.fixed_addr = 3'd3; desc.rdata = 1'b1;
            end
            SEQ_A5_C_READ: begin
                desc.known = 1'b1; desc.fixed_addr = 3'd5;
                desc.mid_conf = 1'b1; desc.rdata = 1'b1;
            end
            SEQ_ERASE: begin
                desc.known = 1'b1; desc.use_ctrl_cnt = 1'b1;
                desc.row_only = 1'b1; desc.end_conf = 1'b1;
            end
            SEQ_PROGRAM: begin
                desc.known = 1'b1; desc.use_ctrl_cnt = 1'b1;
                desc.wdata = 1'b1; desc.end_conf = 1'b1;
            end
            SEQ_STATUS: begin
                desc.known = 1'b1; desc.stat = 1'b1;
            end
            default: desc = '0;
        endcase
    end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              code_known,
    input  logic              busy,
    input  logic              cmd_end,
    input  logic              stat_we,
    input  logic [7:0]        stat_byte,
    input  logic [CHIP_N-1:0] dev_rdy,
    output logic              start,
    output logic [2:0]        cnt_set0,
    output logic [2:0]        cnt_set1,
    output logic [63:0]       addr_set0,
    output logic [63:0]       addr_set1,
    output logic [SIZE_W-1:0] data_len,
    output logic              irq
);
    logic [31:0]       ctrl_q, cmd_q, s0_lo, s0_hi, s1_lo, s1_hi;
    logic [IRQ_W-1:0]  mask_q, istat_q;
    logic [CHIP_N-1:0] rdy_q;
    logic [7:0]        rdstat_q;
    logic              collide_q;
    logic              cmd_wr;

    assign cmd_wr = reg_we && (reg_addr == RG_CMD);
    assign start  = cmd_wr && !busy && code_known;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; cmd_q <= '0; s0_lo <= '0; s0_hi <= '0;
            s1_lo <= '0; s1_hi <= '0; mask_q <= '0; istat_q <= '0;
            rdy_q <= '1; rdstat_q <= '0; collide_q <= 1'b0; data_len <= '0;
        end else begin
            rdy_q <= dev_rdy;
            if (reg_we) begin
                case (reg_addr)
                    RG_CTRL:  ctrl_q   <= reg_wdata;
                    RG_MASK:  mask_q   <= reg_wdata[IRQ_W-1:0];
                    RG_S0_LO: s0_lo    <= reg_wdata;
                    RG_S0_HI: s0_hi    <= reg_wdata;
                    RG_S1_LO: s1_lo    <= reg_wdata;
                    RG_S1_HI: s1_hi    <= reg_wdata;
                    RG_LEN:   data_len <= reg_wdata[SIZE_W-1:0];
                    default: ;
                endcase
            end
            if (start) cmd_q <= reg_wdata;
            if (cmd_wr && busy) collide_q <= 1'b1;
            else if (reg_we && reg_addr == RG_STATUS) collide_q <= 1'b0;
            if (stat_we) rdstat_q <= stat_byte;
            istat_q <= ((reg_we && reg_addr == RG_ISTAT && reg_wdata == 32'd0) ? '0 : istat_q)
                     | {dev_rdy & ~rdy_q, 2'b00, cmd_end, 1'b0};
        end
    end

    always_comb begin
        case (reg_addr)
            RG_CTRL:   reg_rdata = ctrl_q;
            RG_CMD:    reg_rdata = cmd_q;
            RG_STATUS: reg_rdata = {22'd0, collide_q, busy, dev_rdy};
            RG_MASK:   reg_rdata = 32'(mask_q);
            RG_ISTAT:  reg_rdata = 32'(istat_q);
            RG_S0_LO:  reg_rdata = s0_lo;
            RG_S0_HI:  reg_rdata = s0_hi;
            RG_S1_LO:  reg_rdata = s1_lo;
            RG_S1_HI:  reg_rdata = s1_hi;
            RG_LEN:    reg_rdata = 32'(data_len);
            RG_RDSTAT: reg_rdata = {24'd0, rdstat_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign cnt_set0  = ctrl_q[2:0];
    assign cnt_set1  = ctrl_q[20:18];
    assign addr_set0 = {s0_hi, s0_lo};
    assign addr_set1 = {s1_hi, s1_lo};
    assign irq       = |(istat_q & mask_q);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter int GUARD_CYC = 2,
    parameter int SIZE_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  seq_desc_t         desc,
    input  logic              sel_set1,
    input  logic [7:0]        op0,
    input  logic [7:0]        op1,
    input  logic [2:0]        cnt_set0,
    input  logic [2:0]        cnt_set1,
    input  logic [63:0]       addr_set0,
    input  logic [63:0]       addr_set1,
    input  logic [SIZE_W-1:0] data_len,
    input  logic [CHIP_N-1:0] dev_rdy,
    input  logic [7:0]        io_in,
    input  logic [7:0]        wr_byte,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              stat_we,
    output logic [7:0]        stat_byte,
    output logic              cmd_end,
    output logic              busy
);
    localparam int TW = $clog2(PULSE_CYC + 1);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(PULSE_CYC - 1);

    bus_state_t        state;
    phase_t            phase, np;
    seq_desc_t         d_q;
    logic [7:0]        op0_q, op1_q, wbyte_q;
    logic [63:0]       addr_q;
    logic [2:0]        aidx, acnt_q;
    logic [SIZE_W-1:0] len_q, bcnt;
    logic [TW-1:0]     tcnt;
    logic [GW-1:0]     gcnt;
    logic              found;

    function automatic logic phase_on(phase_t p, seq_desc_t d, logic [2:0] ac,
                                      logic [SIZE_W-1:0] ln);
        case (p)
            PH_CMD0:                  return d.known;
            PH_ADDR:                  return ac != 3'd0;
            PH_CONF_MID, PH_WAIT_MID: return d.mid_conf;
            PH_WDATA:                 return d.wdata && (ln != '0);
            PH_CONF_END, PH_WAIT_END: return d.end_conf;
            PH_RDATA:                 return d.rdata && (ln != '0);
            PH_STAT:                  return d.stat;
            default:                  return 1'b1;
        endcase
    endfunction

    function automatic bus_state_t entry_of(phase_t p);
        case (p)
            PH_WAIT_MID, PH_WAIT_END: return ST_WAIT_RB;
            PH_END:                   return ST_FINISH;
            default:                  return ST_SETUP;
        endcase
    endfunction

    function automatic logic is_read(phase_t p);
        return (p == PH_RDATA) || (p == PH_STAT);
    endfunction

    always_comb begin
        np    = PH_END;
        found = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!found && i > int'(phase) && phase_on(phase_t'(i[3:0]), d_q, acnt_q, len_q)) begin
                np    = phase_t'(i[3:0]);
                found = 1'b1;
            end
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE; phase <= PH_END; d_q <= '0;
            op0_q <= '0; op1_q <= '0; wbyte_q <= '0; addr_q <= '0;
            aidx <= '0; acnt_q <= '0; len_q <= '0; bcnt <= '0;
            tcnt <= '0; gcnt <= '0; rd_valid <= 1'b0; rd_byte <= '0;
            stat_we <= 1'b0; stat_byte <= '0; cmd_end <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            stat_we  <= 1'b0;
            cmd_end  <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    d_q    <= desc;
                    op0_q  <= op0;
                    op1_q  <= op1;
                    addr_q <= sel_set1 ? addr_set1 : addr_set0;
                    len_q  <= data_len;
                    if (desc.use_ctrl_cnt) begin
                        acnt_q <= sel_set1 ? cnt_set1 : cnt_set0;
                        aidx   <= desc.row_only ? 3'd2 : 3'd0;
                    end else begin
                        acnt_q <= desc.fixed_addr;
                        aidx   <= 3'd0;
                    end
                    phase <= PH_CMD0;
                    bcnt  <= SIZE_W'(1);
                    tcnt  <= '0;
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    tcnt <= '0;
                    if (is_read(phase)) state <= ST_RE_LO;
                    else begin
                        state <= ST_WE_LO;
                        if (phase == PH_WDATA) wbyte_q <= wr_byte;
                    end
                end
                ST_WE_LO, ST_RE_LO: begin
                    if (tcnt == T_LAST) begin
                        tcnt  <= '0;
                        state <= (state == ST_WE_LO) ? ST_WE_HI : ST_RE_HI;
                        if (state == ST_RE_LO) begin
                            if (phase == PH_STAT) begin
                                stat_we <= 1'b1; stat_byte <= io_in;
                            end else begin
                                rd_valid <= 1'b1; rd_byte <= io_in;
                            end
                        end
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_WE_HI, ST_RE_HI: begin
                    if (tcnt != T_LAST) tcnt <= tcnt + 1'b1;
                    else if (bcnt > SIZE_W'(1)) begin
                        bcnt  <= bcnt - 1'b1;
                        tcnt  <= '0;
                        state <= ST_SETUP;
                        if (phase == PH_ADDR) aidx <= aidx + 1'b1;
                    end else begin
                        phase <= np;
                        state <= entry_of(np);
                        tcnt  <= '0;
                        gcnt  <= GW'(GUARD_CYC);
                        case (np)
                            PH_ADDR:           bcnt <= SIZE_W'(acnt_q);
                            PH_WDATA, PH_RDATA: bcnt <= len_q;
                            default:           bcnt <= SIZE_W'(1);
                        endcase
                    end
                end
                ST_WAIT_RB: begin
                    if (gcnt != '0) gcnt <= gcnt - 1'b1;
                    else if (&dev_rdy) begin
                        phase <= np;
                        state <= entry_of(np);
                        tcnt  <= '0;
                        case (np)
                            PH_WDATA, PH_RDATA: bcnt <= len_q;
                            default:           bcnt <= SIZE_W'(1);
                        endcase
                    end
                end
                ST_FINISH: begin
                    cmd_end <= 1'b1;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // bus outputs
    always_comb begin
        logic wr_ph, drive;
        wr_ph   = !is_read(phase);
        drive   = (state == ST_SETUP) || (state == ST_WE_LO) || (state == ST_WE_HI);
        cle     = drive && (phase == PH_CMD0 || phase == PH_CONF_MID || phase == PH_CONF_END);
        ale     = drive && (phase == PH_ADDR);
        io_oe   = drive && wr_ph;
        we_n    = (state != ST_WE_LO);
        re_n    = (state != ST_RE_LO);
        wr_take = (state == ST_SETUP) && (phase == PH_WDATA);
        busy    = (state != ST_IDLE);
        case (phase)
            PH_CMD0:                  io_out = op0_q;
            PH_CONF_MID, PH_CONF_END: io_out = op1_q;
            PH_ADDR:                  io_out = addr_q[{aidx, 3'b000} +: 8];
            PH_WDATA:                 io_out = wbyte_q;
            default:                  io_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
    import nand_seq_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter int GUARD_CYC = 2,
    parameter int SIZE_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic [7:0]  dev_rdy,
    output logic        rd_valid,
    output logic [7:0]  rd_byte,
    input  logic [7:0]  wr_byte,
    output logic        wr_take,
    output logic        irq
);
    seq_desc_t         desc;
    logic              start, busy, cmd_end, stat_we;
    logic [7:0]        stat_byte;
    logic [2:0]        cnt_set0, cnt_set1;
    logic [63:0]       addr_set0, addr_set1;
    logic [SIZE_W-1:0] data_len;

    nand_seq_decode u_dec (
        .code (reg_wdata[5:0]),
        .desc (desc)
    );

    nand_seq_regs #(.SIZE_W(SIZE_W)) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .code_known (desc.known),
        .busy, .cmd_end, .stat_we, .stat_byte, .dev_rdy,
        .start, .cnt_set0, .cnt_set1, .addr_set0, .addr_set1,
        .data_len, .irq
    );

    nand_seq_fsm #(.PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC), .SIZE_W(SIZE_W)) u_fsm (
        .clk, .rst_n, .start, .desc,
        .sel_set1 (reg_wdata[7]),
        .op0      (reg_wdata[15:8]),
        .op1      (reg_wdata[23:16]),
        .cnt_set0, .cnt_set1, .addr_set0, .addr_set1, .data_len, .dev_rdy,
        .io_in    (nand_io_in),
        .wr_byte,
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .io_out   (nand_io_out),
        .io_oe    (nand_io_oe),
        .wr_take, .rd_valid, .rd_byte, .stat_we, .stat_byte, .cmd_end, .busy
    );
endmodule

// File: rtl/nand_seq_engine_chk.sv
module nand_seq_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_io_oe,
    input logic wr_take
);
    a_r11_setup_before_we_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> $stable(nand_cle) && $stable(nand_ale));

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r11_cle_ale_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r11_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);

    a_r11_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    a_r6_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !wr_take);
endmodule

bind nand_seq_engine nand_seq_engine_chk u_chk (
    .clk, .rst_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n, .nand_io_oe, .wr_take
);

// File: tb/nand_seq_engine_tb_top.sv
module nand_seq_engine_tb_top;
    localparam int P = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        cle, ale, we_n, re_n, io_oe, rd_valid, wr_take, irq;
    logic [7:0]  io_out, io_in, dev_rdy, rd_byte, wr_byte;

    int n_chk = 0, n_fail = 0;
    logic [9:0] log_q [0:63];
    logic [7:0] rd_log [0:63];
    int log_n = 0, rd_n = 0, rd_idx = 0, wr_idx = 0, busy_cnt = 0;
    int we_run = 0, re_run = 0, t_bad = 0, t_seen = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, take_seen = 1'b0, prem = 1'b0, seen_fe = 1'b0;

    always #2 clk = ~clk;

    assign io_in   = 8'hA0 + rd_idx[7:0];
    assign wr_byte = 8'h50 + wr_idx[7:0];
    assign dev_rdy = {7'h7F, busy_cnt == 0};

    nand_seq_engine #(.PULSE_CYC(P)) dut_i (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in),
        .dev_rdy, .rd_valid, .rd_byte, .wr_byte, .wr_take, .irq
    );

    // flash model and monitors
    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (!prev_we && we_n) begin
            log_q[log_n[5:0]] = {cle ? 2'd1 : ale ? 2'd2 : 2'd3, io_out};
            log_n = log_n + 1;
            if (cle && (io_out == 8'h30 || io_out == 8'hD0 || io_out == 8'h10)) busy_cnt <= 12;
            if (we_run != P) t_bad++;
            t_seen++;
        end
        if (!prev_re && re_n) begin
            rd_idx = rd_idx + 1;
            if (re_run != P) t_bad++;
            t_seen++;
        end
        we_run = we_n ? 0 : we_run + 1;
        re_run = re_n ? 0 : re_run + 1;
        prev_we = we_n;
        prev_re = re_n;
        if (rd_valid) begin rd_log[rd_n[5:0]] = rd_byte; rd_n = rd_n + 1; end
        if (take_seen) wr_idx = wr_idx + 1;
        take_seen = wr_take;
        if (busy_cnt != 0 && irq) prem = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            rd_reg(4'd2, s);
            if (s[8] && s[7:0] == 8'hFE) seen_fe = 1'b1;
            if (!s[8]) break;
        end
    endtask

    task automatic run(input logic [31:0] w);
        wr_reg(4'd4, 32'd0);
        @(negedge clk);
        log_n = 0; rd_n = 0; rd_idx = 0; wr_idx = 0; prem = 1'b0;
        wr_reg(4'd1, w);
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    function automatic int count_kind(input logic [1:0] k);
        int c = 0;
        for (int i = 0; i < log_n; i++) if (log_q[i][9:8] == k) c++;
        return c;
    endfunction

    // {command word, #cmd, #addr, #write data, #read data}
    localparam logic [63:0] VEC [0:6] = '{
        {32'h0000_FF00, 8'd1, 8'd0, 8'd0, 8'd0},
        {32'h0000_9021, 8'd1, 8'd1, 8'd0, 8'd4},
        {32'h0000_9027, 8'd1, 8'd3, 8'd0, 8'd4},
        {32'h0030_002A, 8'd2, 8'd5, 8'd0, 8'd4},
        {32'h00D0_600E, 8'd2, 8'd4, 8'd0, 8'd0},
        {32'h0010_800C, 8'd2, 8'd4, 8'd4, 8'd0},
        {32'h0000_7024, 8'd1, 8'd0, 8'd0, 8'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 pins", {30'd0, cle, ale}, 32'd0);
        chk("R1 strobes", {30'd0, we_n, re_n}, 32'd3);
        chk("R1 oe irq", {30'd0, io_oe, irq}, 32'd0);
        rd_reg(4'd2, d);
        chk("R1 status", d, 32'h0000_00FF);

        wr_reg(4'd0, 32'h000C_0004);
        wr_reg(4'd5, 32'h5678_1234);
        wr_reg(4'd6, 32'h0000_0009);
        wr_reg(4'd7, 32'hCDEF_AB01);
        wr_reg(4'd8, 32'h0000_0000);
        wr_reg(4'd9, 32'd4);
        wr_reg(4'd3, 32'h0000_0002);

        // table walk: R2..R7 phase counts per code
        for (int v = 0; v < 7; v++) begin
            run(VEC[v][63:32]);
            chk("R2 cmd count", count_kind(2'd1), 32'(VEC[v][31:24]));
            chk("R3 addr count", count_kind(2'd2), 32'(VEC[v][23:16]));
            chk("R6 wdata count", count_kind(2'd3), 32'(VEC[v][15:8]));
            chk("R4 rd count", rd_n, 32'(VEC[v][7:0]));
            chk("R2 first opcode", 32'(log_q[0][7:0]), 32'(VEC[v][47:40]));
            chk("R10 cmd end irq", {31'd0, irq}, 32'd1);
            chk("R5 no early end", {31'd0, prem}, 32'd0);
        end

        // R3 / R4: address order and read stream for 0x2a
        run(32'h0030_002A);
        chk("R3 a0", 32'(log_q[1][7:0]), 32'h34);
        chk("R3 a1", 32'(log_q[2][7:0]), 32'h12);
        chk("R3 a2", 32'(log_q[3][7:0]), 32'h78);
        chk("R3 a3", 32'(log_q[4][7:0]), 32'h56);
        chk("R3 a4", 32'(log_q[5][7:0]), 32'h09);
        chk("R4 confirm", 32'(log_q[6]), {22'd0, 2'd1, 8'h30});
        for (int i = 0; i < 4; i++) chk("R4 rd data", 32'(rd_log[i]), 32'(8'hA0 + i));

        // R5 erase: page bytes only, wait for ready
        seen_fe = 1'b0;
        run(32'h00D0_600E);
        chk("R5 row b2", 32'(log_q[1][7:0]), 32'h78);
        chk("R5 row b4", 32'(log_q[3][7:0]), 32'h09);
        chk("R5 confirm", 32'(log_q[5]), {22'd0, 2'd1, 8'hD0});
        chk("R5 end after ready", {31'd0, prem}, 32'd0);
        chk("R9 ready lines seen busy", {31'd0, seen_fe}, 32'd1);

        // R6 program with data
        run(32'h0010_800C);
        for (int i = 0; i < 4; i++) chk("R6 wdata", 32'(log_q[5 + i][7:0]), 32'(8'h50 + i));
        chk("R6 last is confirm", 32'(log_q[9]), {22'd0, 2'd1, 8'h10});

        // R8 set 1 with count 3
        run(32'h0010_808C);
        chk("R8 addr count", count_kind(2'd2), 32'd3);
        chk("R8 a0", 32'(log_q[1][7:0]), 32'h01);
        chk("R8 a2", 32'(log_q[3][7:0]), 32'hEF);

        // R7 status byte
        run(32'h0000_7024);
        rd_reg(4'd10, d);
        chk("R7 read status", d, 32'h0000_00A0);
        chk("R7 not on stream", rd_n, 32'd0);

        // R9 collision
        wr_reg(4'd4, 32'd0);
        log_n = 0;
        wr_reg(4'd1, 32'h0000_FF00);
        rd_reg(4'd2, d);
        chk("R9 busy bit", {31'd0, d[8]}, 32'd1);
        wr_reg(4'd1, 32'h0000_EE00);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R9 second ignored", log_n, 32'd1);
        rd_reg(4'd2, d);
        chk("R9 sticky set", {31'd0, d[9]}, 32'd1);
        wr_reg(4'd2, 32'd0);
        rd_reg(4'd2, d);
        chk("R9 sticky cleared", {31'd0, d[9]}, 32'd0);

        // R10 ready-edge interrupt and clearing
        wr_reg(4'd3, 32'h0000_0010);
        run(32'h00D0_600E);
        rd_reg(4'd4, d);
        chk("R10 istat", d & 32'h12, 32'h12);
        chk("R10 irq masked rdy", {31'd0, irq}, 32'd1);
        wr_reg(4'd4, 32'h0000_0001);
        rd_reg(4'd4, d);
        chk("R10 nonzero write keeps", d & 32'h12, 32'h12);
        wr_reg(4'd4, 32'd0);
        rd_reg(4'd4, d);
        chk("R10 clear", d, 32'd0);
        chk("R10 irq low", {31'd0, irq}, 32'd0);

        // R12 unknown code
        wr_reg(4'd3, 32'h0000_0002);
        run(32'h0000_AA3F);
        chk("R12 no bus", log_n, 32'd0);
        chk("R12 no end", {31'd0, irq}, 32'd0);

        // R13 zero length
        wr_reg(4'd9, 32'd0);
        run(32'h0000_9021);
        chk("R13 addr", count_kind(2'd2), 32'd1);
        chk("R13 no data", rd_n, 32'd0);
        chk("R13 end", {31'd0, irq}, 32'd1);

        // R11 strobe widths
        chk("R11 widths", t_bad, 32'd0);
        chk("R11 strobes seen", {31'd0, t_seen > 20}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule